// File: doc/BRIEF.md
# Single-Cycle Call-and-Return Processor Core

This block is a small 32-bit processor core that completes one instruction per clock. It executes four instructions: add-immediate, register add, jump-and-link with a PC-relative offset, and jump-and-link through a register. These are enough to call a subroutine and return from it. One adder computes every result. Operand selectors in front of it choose between the PC and the first source register on one side, and between the second source register, the I-format immediate and the J-format immediate on the other. A write-data selector chooses between the adder result and PC+4, which is the return address. A next-PC selector chooses between PC+4 and the adder result.

The core fetches from an external instruction memory through a combinational read port addressed by the PC. A run enable gates every state update. When the core meets the all-zero word or any other word it does not recognize, it raises halt and holds the PC there. Debug taps show the PC and any selected register. The active-low reset clears all state asynchronously. Its release is synchronized inside the core with two flops, so execution starts at PC 0 on the third rising edge after release, provided the enable is high.

Top module: `jmp_core`

## Requirements
- R1: While reset is applied and after it is released, the PC reads 0 and every register reads 0 through the debug taps.
- R2: While the run enable is low, neither the PC nor any register changes.
- R3: Add-immediate (opcode 0010011, funct3 000) writes rs1 plus the sign-extended inst[31:20] into rd. Register add (opcode 0110011, funct3 000, funct7 0000000) writes rs1 plus rs2 into rd. After either instruction the PC advances by 4.
- R4: Jump-and-link (opcode 1101111) writes PC+4 into rd. It moves the PC to the current PC plus the J immediate. The J immediate is sign-extended from bit 20 and built from inst[31] as bit 20, inst[19:12] as bits 19:12, inst[20] as bit 11 and inst[30:21] as bits 10:1, with bit 0 zero. Negative offsets jump backwards.
- R5: Jump-through-register (opcode 1100111, funct3 000) writes PC+4 into rd and moves the PC to rs1 plus the sign-extended inst[31:20].
- R6: Register x0 always reads 0. A write to it, including the link of a jump, is discarded, so the jump still takes place.
- R7: The all-zero instruction word raises halt. While it is fetched, the PC stays put and no register is written.
- R8: Any other unrecognized word also raises halt and freezes the core. This includes register add with a nonzero funct7 and add-immediate with a nonzero funct3.
- R9: The instruction-memory address and the debug PC tap both equal the current PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low reset, release synchronized inside |
| run_en_i | input | 1 | Gates all PC and register updates |
| imem_addr_o | output | 32 | Byte address of the instruction to fetch (the PC) |
| imem_data_i | input | 32 | Instruction word returned combinationally for imem_addr_o |
| halt_o | output | 1 | High while the fetched word is unimp or unrecognized |
| dbg_pc_o | output | 32 | Current PC |
| dbg_reg_sel_i | input | 5 | Register index shown on dbg_reg_val_o |
| dbg_reg_val_o | output | 32 | Value of the selected register |

## Verification
Every instruction commits at the rising edge after it appears on imem_data_i while the core runs. Its new PC and its register write are therefore visible one clock later, and halt follows the fetched word combinationally in the same cycle. The bench drives inputs and samples outputs on the falling edge. A trace step placed one falling edge after the enabling edge checks exactly one retired instruction. Register values are read by changing the debug select and waiting a short settle delay before sampling. Startup allows for the two synchronizer flops, so the first instruction commits on the third rising edge after reset release.

// File: rtl/jmp_core_pkg.sv
package jmp_core_pkg;
  localparam int XLEN = 32;

  localparam logic [6:0] OPC_IMM  = 7'b0010011;
  localparam logic [6:0] OPC_REG  = 7'b0110011;
  localparam logic [6:0] OPC_JAL  = 7'b1101111;
  localparam logic [6:0] OPC_JALR = 7'b1100111;

  localparam logic [2:0] ALU_ADD = 3'b000;

  typedef enum logic [1:0] {
    OPB_RS2  = 2'b00,
    OPB_IMMI = 2'b01,
    OPB_IMMJ = 2'b10
  } opb_sel_e;

  typedef struct packed {
    logic       rf_we;
    logic [2:0] alu_op;
    opb_sel_e   opb_sel;
    logic       opa_pc;
    logic       wd_link;
    logic       pc_jump;
    logic       halt;
  } ctrl_t;
endpackage

// File: rtl/jmp_decode.sv
module jmp_decode
  import jmp_core_pkg::*;
(
  input  logic [31:0] inst_i,
  output ctrl_t       ctrl_o
);
  logic [6:0] opc;
  logic [2:0] f3;
  logic [6:0] f7;

  assign opc = inst_i[6:0];
  assign f3  = inst_i[14:12];
  assign f7  = inst_i[31:25];

  always_comb begin
    ctrl_o         = '0;
    ctrl_o.alu_op  = ALU_ADD;
    ctrl_o.opb_sel = OPB_RS2;
    ctrl_o.halt    = 1'b1;
    if (opc == OPC_IMM && f3 == 3'b000) begin
      ctrl_o.rf_we   = 1'b1;
      ctrl_o.opb_sel = OPB_IMMI;
      ctrl_o.halt    = 1'b0;
    end else if (opc == OPC_REG && f3 == 3'b000 && f7 == 7'b0) begin
      ctrl_o.rf_we   = 1'b1;
      ctrl_o.halt    = 1'b0;
    end else if (opc == OPC_JAL) begin
      ctrl_o.rf_we   = 1'b1;
      ctrl_o.opb_sel = OPB_IMMJ;
      ctrl_o.opa_pc  = 1'b1;
      ctrl_o.wd_link = 1'b1;
      ctrl_o.pc_jump = 1'b1;
      ctrl_o.halt    = 1'b0;
    end else if (opc == OPC_JALR && f3 == 3'b000) begin
      ctrl_o.rf_we   = 1'b1;
      ctrl_o.opb_sel = OPB_IMMI;
      ctrl_o.wd_link = 1'b1;
      ctrl_o.pc_jump = 1'b1;
      ctrl_o.halt    = 1'b0;
    end
  end
endmodule

// File: rtl/jmp_imm.sv
module jmp_imm #(
  parameter int W = 32
) (
  input  logic [31:0]  inst_i,
  output logic [W-1:0] imm_i_o,
  output logic [W-1:0] imm_j_o
);
  localparam int IW = 12;
  localparam int JW = 21;

  logic [IW-1:0] raw_i;
  logic [JW-1:0] raw_j;

  assign raw_i = inst_i[31:20];
  assign raw_j = {inst_i[31], inst_i[19:12], inst_i[20], inst_i[30:21], 1'b0};

  assign imm_i_o = {{(W-IW){raw_i[IW-1]}}, raw_i};
  assign imm_j_o = {{(W-JW){raw_j[JW-1]}}, raw_j};
endmodule

// File: rtl/jmp_alu.sv
module jmp_alu
  import jmp_core_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [2:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] y_o
);
  always_comb begin
    unique case (op_i)
      ALU_ADD: y_o = a_i + b_i;
      default: y_o = a_i + b_i;
    endcase
  end
endmodule

// File: rtl/jmp_regfile.sv
module jmp_regfile #(
  parameter int W     = 32,
  parameter int NREG  = 32,
  localparam int AW   = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] ra1_i,
  input  logic [AW-1:0] ra2_i,
  input  logic [AW-1:0] rad_i,
  output logic [W-1:0]  rd1_o,
  output logic [W-1:0]  rd2_o,
  output logic [W-1:0]  rdd_o
);
  logic [W-1:0] regs [NREG];

  assign regs[0] = '0;

  for (genvar g = 1; g < NREG; g++) begin : g_reg
    logic         wr_hit;
    logic [W-1:0] reg_d;
    logic [W-1:0] reg_q;

    assign wr_hit = we_i && (waddr_i == AW'(g));

    always_comb begin
      reg_d = reg_q;
      if (wr_hit) reg_d = wdata_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) reg_q <= '0;
      else if (wr_hit) reg_q <= reg_d;
    end

    assign regs[g] = reg_q;
  end

  assign rd1_o = regs[ra1_i];
  assign rd2_o = regs[ra2_i];
  assign rdd_o = regs[rad_i];
endmodule

// File: rtl/jmp_core.sv
module jmp_core
  import jmp_core_pkg::*;
#(
  parameter int W    = XLEN,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_en_i,
  output logic [W-1:0]  imem_addr_o,
  input  logic [31:0]   imem_data_i,
  output logic          halt_o,
  output logic [W-1:0]  dbg_pc_o,
  input  logic [AW-1:0] dbg_reg_sel_i,
  output logic [W-1:0]  dbg_reg_val_o
);
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic [SYNC_STAGES-1:0] rst_sync_d;
  logic                   core_run;
  logic [W-1:0]           pc_q;
  logic [W-1:0]           pc_d;
  logic [W-1:0]           pc_plus4;
  ctrl_t                  ctrl;
  logic [W-1:0]           imm_i;
  logic [W-1:0]           imm_j;
  logic [W-1:0]           rs1_val;
  logic [W-1:0]           rs2_val;
  logic [W-1:0]           opa;
  logic [W-1:0]           opb;
  logic [W-1:0]           alu_res;
  logic [W-1:0]           rf_wdata;
  logic                   rf_we_eff;
  logic                   pc_en;

  // reset release synchronizer
  assign rst_sync_d = {rst_sync_q[SYNC_STAGES-2:0], 1'b1};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= rst_sync_d;
  end

  assign core_run = rst_sync_q[SYNC_STAGES-1] && run_en_i;

  jmp_decode u_dec (
    .inst_i (imem_data_i),
    .ctrl_o (ctrl)
  );

  jmp_imm #(.W(W)) u_imm (
    .inst_i  (imem_data_i),
    .imm_i_o (imm_i),
    .imm_j_o (imm_j)
  );

  jmp_regfile #(.W(W), .NREG(NREG)) u_rf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (rf_we_eff),
    .waddr_i (imem_data_i[7+AW-1:7]),
    .wdata_i (rf_wdata),
    .ra1_i   (imem_data_i[15+AW-1:15]),
    .ra2_i   (imem_data_i[20+AW-1:20]),
    .rad_i   (dbg_reg_sel_i),
    .rd1_o   (rs1_val),
    .rd2_o   (rs2_val),
    .rdd_o   (dbg_reg_val_o)
  );

  // operand selection
  always_comb begin
    opa = ctrl.opa_pc ? pc_q : rs1_val;
    unique case (ctrl.opb_sel)
      OPB_IMMI: opb = imm_i;
      OPB_IMMJ: opb = imm_j;
      default:  opb = rs2_val;
    endcase
  end

  jmp_alu #(.W(W)) u_alu (
    .op_i (ctrl.alu_op),
    .a_i  (opa),
    .b_i  (opb),
    .y_o  (alu_res)
  );

  assign pc_plus4  = pc_q + W'(4);
  assign rf_wdata  = ctrl.wd_link ? pc_plus4 : alu_res;
  assign pc_en     = core_run && !ctrl.halt;
  assign rf_we_eff = pc_en && ctrl.rf_we;

  always_comb begin
    pc_d = pc_q;
    if (pc_en) pc_d = ctrl.pc_jump ? alu_res : pc_plus4;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pc_q <= '0;
    else if (pc_en) pc_q <= pc_d;
  end

  assign imem_addr_o = pc_q;
  assign dbg_pc_o    = pc_q;
  assign halt_o      = ctrl.halt;
endmodule

// File: rtl/jmp_core_chk.sv
module jmp_core_chk #(
  parameter int W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         run_i,
  input logic         halt_i,
  input logic         jump_i,
  input logic [W-1:0] pc_i,
  input logic [W-1:0] alu_i,
  input logic [W-1:0] wdata_i,
  input logic         we_i
);
  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(pc_i));

  p_seq_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !halt_i && !jump_i) |=> (pc_i == $past(pc_i) + W'(4)));

  p_link_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !halt_i && jump_i) |-> (wdata_i == pc_i + W'(4)));

  p_target_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !halt_i && jump_i) |=> (pc_i == $past(alu_i)));

  p_freeze_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && halt_i) |=> $stable(pc_i));

  p_nowrite_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_i |-> !we_i);
endmodule

bind jmp_core jmp_core_chk #(.W(W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .run_i   (core_run),
  .halt_i  (halt_o),
  .jump_i  (ctrl.pc_jump),
  .pc_i    (pc_q),
  .alu_i   (alu_res),
  .wdata_i (rf_wdata),
  .we_i    (rf_we_eff)
);

// File: tb/jmp_core_test.sv
module jmp_core_test;
  localparam int CLK_PERIOD = 10;
  localparam int MEMW = 16;
  localparam int STEPS = 6;

  localparam logic [6:0] OP_IMM  = 7'b0010011;
  localparam logic [6:0] OP_REG  = 7'b0110011;
  localparam logic [6:0] OP_JAL  = 7'b1101111;
  localparam logic [6:0] OP_JALR = 7'b1100111;

  // trace of the call/return program: after each step, PC, a register and halt
  localparam logic [31:0] EXP_PC   [STEPS] = '{32'd4, 32'd8, 32'd16, 32'd20, 32'd12, 32'd12};
  localparam logic [4:0]  EXP_REG  [STEPS] = '{5'd10, 5'd11, 5'd1, 5'd10, 5'd0, 5'd10};
  localparam logic [31:0] EXP_VAL  [STEPS] = '{32'd1, 32'd2, 32'd12, 32'd3, 32'd0, 32'd3};
  localparam logic        EXP_HALT [STEPS] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1};
  localparam string       EXP_TAG  [STEPS] = '{"R3", "R3", "R4", "R3", "R5", "R7"};

  logic        clk = 1'b0;
  logic        rst_n;
  logic        run_en;
  logic [31:0] imem_addr;
  logic [31:0] imem_data;
  logic        halt;
  logic [31:0] dbg_pc;
  logic [4:0]  dbg_sel;
  logic [31:0] dbg_val;
  logic [31:0] imem [MEMW];

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign imem_data = imem[imem_addr[5:2]];

  jmp_core uut (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .run_en_i      (run_en),
    .imem_addr_o   (imem_addr),
    .imem_data_i   (imem_data),
    .halt_o        (halt),
    .dbg_pc_o      (dbg_pc),
    .dbg_reg_sel_i (dbg_sel),
    .dbg_reg_val_o (dbg_val)
  );

  function automatic logic [31:0] enc_i(int imm, int rs1, int rd, logic [2:0] f3, logic [6:0] op);
    logic [11:0] im;
    im = 12'(imm);
    return {im, 5'(rs1), f3, 5'(rd), op};
  endfunction

  function automatic logic [31:0] enc_r(logic [6:0] f7, int rs2, int rs1, int rd);
    return {f7, 5'(rs2), 5'(rs1), 3'b000, 5'(rd), OP_REG};
  endfunction

  function automatic logic [31:0] enc_j(int imm, int rd);
    logic [20:0] im;
    im = 21'(imm);
    return {im[20], im[10:1], im[11], im[19:12], 5'(rd), OP_JAL};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic read_reg(int idx, output logic [31:0] val);
    dbg_sel = 5'(idx);
    #1;
    val = dbg_val;
  endtask

  task automatic clear_mem();
    for (int i = 0; i < MEMW; i++) imem[i] = 32'h0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n  = 1'b0;
    run_en = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic run_cycles(int n);
    run_en = 1'b1;
    repeat (n) @(negedge clk);
    run_en = 1'b0;
  endtask

  initial begin
    logic [31:0] v;
    rst_n   = 1'b0;
    run_en  = 1'b0;
    dbg_sel = 5'd0;

    // program 1: call and return
    clear_mem();
    imem[0] = enc_i(1, 0, 10, 3'b000, OP_IMM);
    imem[1] = enc_i(2, 0, 11, 3'b000, OP_IMM);
    imem[2] = enc_j(8, 1);
    imem[3] = 32'h0;
    imem[4] = enc_r(7'b0, 11, 10, 10);
    imem[5] = enc_i(0, 1, 0, 3'b000, OP_JALR);
    do_reset();

    // R1: reset state
    check("R1 pc", dbg_pc, 32'd0);
    for (int r = 0; r < 32; r += 5) begin
      read_reg(r, v);
      check("R1 reg", v, 32'd0);
    end
    read_reg(31, v);
    check("R1 reg31", v, 32'd0);
    // R9: fetch address follows the PC
    check("R9 addr", imem_addr, dbg_pc);

    // R2: enable low holds everything
    repeat (4) @(negedge clk);
    check("R2 pc", dbg_pc, 32'd0);
    read_reg(10, v);
    check("R2 reg", v, 32'd0);

    // trace walk: one instruction retires per enabled cycle
    run_en = 1'b1;
    for (int s = 0; s < STEPS; s++) begin
      @(negedge clk);
      check({EXP_TAG[s], " pc"}, dbg_pc, EXP_PC[s]);
      check({EXP_TAG[s], " halt"}, {31'b0, halt}, {31'b0, EXP_HALT[s]});
      read_reg(EXP_REG[s], v);
      check({EXP_TAG[s], " reg"}, v, EXP_VAL[s]);
      check("R9 addr", imem_addr, dbg_pc);
    end
    repeat (3) @(negedge clk);
    run_en = 1'b0;
    check("R7 pc frozen", dbg_pc, 32'd12);
    read_reg(1, v);
    check("R7 ra kept", v, 32'd12);
    read_reg(11, v);
    check("R3 a1 kept", v, 32'd2);

    // program 2: plain jump, backward call, offset register jump, x0 write, bad word
    clear_mem();
    imem[0] = enc_j(16, 0);
    imem[4] = enc_j(-12, 3);
    imem[1] = enc_i(-5, 0, 6, 3'b000, OP_IMM);
    imem[2] = enc_i(8, 3, 7, 3'b000, OP_JALR);
    imem[3] = 32'h0;
    imem[7] = enc_i(9, 0, 0, 3'b000, OP_IMM);
    imem[8] = 32'hFFFF_FFFF;
    do_reset();
    run_en = 1'b1;
    @(negedge clk);
    check("R6 plain jump pc", dbg_pc, 32'd16);
    @(negedge clk);
    check("R4 backward pc", dbg_pc, 32'd4);
    run_cycles(6);
    check("R8 pc", dbg_pc, 32'd32);
    check("R8 halt", {31'b0, halt}, 32'd1);
    read_reg(0, v);
    check("R6 x0", v, 32'd0);
    read_reg(3, v);
    check("R4 link", v, 32'd20);
    read_reg(6, v);
    check("R3 negative imm", v, 32'hFFFF_FFFB);
    read_reg(7, v);
    check("R5 link", v, 32'd12);

    // program 3: add with nonzero funct7 is unrecognized
    clear_mem();
    imem[0] = enc_i(5, 0, 1, 3'b000, OP_IMM);
    imem[1] = enc_r(7'b0100000, 1, 1, 2);
    do_reset();
    run_cycles(4);
    check("R8 funct7 pc", dbg_pc, 32'd4);
    check("R8 funct7 halt", {31'b0, halt}, 32'd1);
    read_reg(2, v);
    check("R8 funct7 no write", v, 32'd0);
    read_reg(1, v);
    check("R3 addi", v, 32'd5);

    // program 4: add-immediate with nonzero funct3 is unrecognized
    clear_mem();
    imem[0] = enc_i(3, 0, 1, 3'b001, OP_IMM);
    do_reset();
    run_cycles(3);
    check("R8 funct3 pc", dbg_pc, 32'd0);
    check("R8 funct3 halt", {31'b0, halt}, 32'd1);
    read_reg(1, v);
    check("R8 funct3 no write", v, 32'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule